// File: doc/BRIEF.md
# SMBus Host Block Data Buffer

This block is the 32-entry block data store that sits behind the block data register of an SMBus host controller. Software turns buffer mode on with a bit in an auxiliary control register. In that mode, a whole block is pushed through the block data register before a transfer starts, or pulled out through it after the transfer ends. Each access to the register moves a software-side index forward by one. Reading the host control register returns that index to zero. The length of the block sits in a separate length register, and a flag shows whether the length is in the legal range.

The bus engine has its own port into the same storage, with its own index. The engine resets that index at the start of a transfer and then fills or drains entries one at a time, up to the stored length. When buffer mode is off, the block data register becomes a single holding byte shared by software and the engine. In that mode a byte-done flag paces the exchange: the engine sets it and software clears it. The transaction sequencer and the CRC engine are outside this block.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset the buffer enable and CRC enable are 0, the length is 0, both indices are 0, byte_done is 0 and every buffer entry reads 0.
- R2: A write to register select 3 (auxiliary control) sets the CRC enable from data bit 0 and the buffer enable from data bit 1. A read of select 3 returns those two bits in the same positions, with all other bits 0.
- R3: With buffer mode on, a write to select 2 (block data) stores the byte at the software index. A read of select 2 returns the entry at the software index. Either access then advances the index by one.
- R4: A read of select 0 (host control) returns 0 and sets the software index to 0 in either mode.
- R5: The software and bus indices stop at 32. At index 32, a write is dropped and leaves all 32 entries unchanged, and a read returns 0.
- R6: With buffer mode on, a read through either port at an index equal to or above the stored length returns 0.
- R7: Select 1 holds the 8-bit block length, which is written by software or by the bus port's length strobe. len_ok is 1 exactly when the length is between 1 and 32.
- R8: bus_start sets the bus index to 0 and performs no access in that cycle. bus_wr and bus_rd write or read the entry at the bus index and advance it, independently of the software index. bus_done is 1 in buffer mode when the bus index is at or above the length.
- R9: With buffer mode off, select 2 is a single holding byte and the indices do not move. bus_wr loads the holding byte, and bus_rdata shows it. Any bus byte transfer sets byte_done, and a software access to select 2 clears it.
- R10: Clearing either enable bit, and any traffic in byte mode, leaves the 32 buffer entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_sel | input | 2 | Register select: 0 control, 1 length, 2 block data, 3 auxiliary |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data for the selected register |
| bus_start | input | 1 | Resets the bus index at transfer start |
| bus_wr | input | 1 | Bus engine writes one byte |
| bus_rd | input | 1 | Bus engine consumes one byte |
| bus_len_we | input | 1 | Bus engine loads the length from bus_wdata |
| bus_wdata | input | 8 | Bus engine write data |
| bus_rdata | output | 8 | Byte at the bus index, or the holding byte in byte mode |
| bus_done | output | 1 | Bus index has reached the length |
| len_ok | output | 1 | Length is between 1 and 32 |
| byte_done | output | 1 | Byte-mode handshake flag |
| buf_en | output | 1 | Buffer mode enable |
| crc_en | output | 1 | CRC enable |

## Verification
The hardest state to reach is the saturated software index. The stimulus sets the length to 32 and writes 34 bytes without touching the control register, so the last two writes land on the stop point. A full read-back then shows that entry 0 and entry 31 kept their values, and that the read past the end returns 0. A second hard case is leaving buffer mode while the buffer holds data. The stimulus runs holding-byte exchanges and byte-done handshakes in byte mode, then turns the buffer back on and resets the index. The read-back must return the bytes the bus port stored before the switch.

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sw_sel,
  input  logic          sw_wr,
  input  logic          sw_rd,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] sw_rdata,
  input  logic          bus_start,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_len_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_done,
  output logic          len_ok,
  output logic          byte_done,
  output logic          buf_en,
  output logic          crc_en
);
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_LEN = 2'd1;
  localparam logic [1:0] SEL_BLK = 2'd2;
  localparam logic [1:0] SEL_AUX = 2'd3;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] hold, len_q;
  logic [IW-1:0] sidx, bidx;

  wire sw_blk_wr = sw_wr && (sw_sel == SEL_BLK);
  wire sw_blk_rd = sw_rd && (sw_sel == SEL_BLK);
  wire ctl_rd    = sw_rd && (sw_sel == SEL_CTL);

  wire s_in  = int'(sidx) < DEPTH;
  wire b_in  = int'(bidx) < DEPTH;
  wire s_vis = s_in && (int'(sidx) < int'(len_q));
  wire b_vis = b_in && (int'(bidx) < int'(len_q));

  wire [DW-1:0] s_data = s_vis ? mem[sidx[IW-2:0]] : '0;
  wire [DW-1:0] b_data = b_vis ? mem[bidx[IW-2:0]] : '0;

  always_comb begin
    case (sw_sel)
      SEL_LEN: sw_rdata = len_q;
      SEL_BLK: sw_rdata = buf_en ? s_data : hold;
      SEL_AUX: sw_rdata = {{(DW-2){1'b0}}, buf_en, crc_en};
      default: sw_rdata = '0;
    endcase
  end

  assign bus_rdata = buf_en ? b_data : hold;
  assign bus_done  = buf_en && (int'(bidx) >= int'(len_q));
  assign len_ok    = (len_q != '0) && (int'(len_q) <= DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (buf_en) begin
      if (bus_wr && !bus_start && b_in) mem[bidx[IW-2:0]] <= bus_wdata;
      if (sw_blk_wr && s_in) mem[sidx[IW-2:0]] <= sw_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sidx <= '0;
    else if (ctl_rd) sidx <= '0;
    else if (buf_en && (sw_blk_wr || sw_blk_rd) && s_in) sidx <= sidx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bidx <= '0;
    else if (bus_start) bidx <= '0;
    else if (buf_en && (bus_wr || bus_rd) && b_in) bidx <= bidx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else if (sw_wr && (sw_sel == SEL_LEN)) len_q <= sw_wdata;
    else if (bus_len_we) len_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en <= 1'b0;
      crc_en <= 1'b0;
    end else if (sw_wr && (sw_sel == SEL_AUX)) begin
      buf_en <= sw_wdata[1];
      crc_en <= sw_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      byte_done <= 1'b0;
    end else if (!buf_en) begin
      if (sw_blk_wr) hold <= sw_wdata;
      else if (bus_wr) hold <= bus_wdata;
      if (bus_wr || bus_rd) byte_done <= 1'b1;
      else if (sw_blk_wr || sw_blk_rd) byte_done <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_blkbuf_chk.sv
module smb_blkbuf_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int IW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    sw_sel,
  input logic          sw_wr,
  input logic          sw_rd,
  input logic [DW-1:0] sw_wdata,
  input logic [DW-1:0] sw_rdata,
  input logic          bus_start,
  input logic          len_ok,
  input logic          buf_en,
  input logic          crc_en,
  input logic [IW-1:0] sidx,
  input logic [IW-1:0] bidx,
  input logic [DW-1:0] len_q
);
  AST_AUX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr && sw_sel == 2'd3 |=> buf_en == $past(sw_wdata[1]) && crc_en == $past(sw_wdata[0])); // R2
  AST_CTL_RD_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rd && sw_sel == 2'd0 |=> sidx == '0); // R4
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sidx) <= DEPTH && int'(bidx) <= DEPTH); // R5
  AST_PAST_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en && sw_sel == 2'd2 && int'(sidx) >= int'(len_q) |-> sw_rdata == '0); // R6
  AST_ZERO_LEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr && sw_sel == 2'd1 && sw_wdata == '0 |=> !len_ok); // R7
  AST_BUS_START: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> bidx == '0); // R8
  AST_BYTE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en && sw_sel == 2'd2 && (sw_rd || sw_wr) |=> $stable(sidx)); // R9
endmodule

bind smb_blkbuf smb_blkbuf_chk #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_sel(sw_sel), .sw_wr(sw_wr), .sw_rd(sw_rd),
  .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .bus_start(bus_start),
  .len_ok(len_ok), .buf_en(buf_en), .crc_en(crc_en),
  .sidx(sidx), .bidx(bidx), .len_q(len_q)
);

// File: tb/tb_smb_blkbuf.sv
module tb_smb_blkbuf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sw_sel = '0;
  logic sw_wr = 0, sw_rd = 0, bus_start = 0, bus_wr = 0, bus_rd = 0, bus_len_we = 0;
  logic [7:0] sw_wdata = '0, bus_wdata = '0;
  logic [7:0] sw_rdata, bus_rdata;
  logic bus_done, len_ok, byte_done, buf_en, crc_en;

  smb_blkbuf dut (
    .clk(clk), .rst_n(rst_n), .sw_sel(sw_sel), .sw_wr(sw_wr), .sw_rd(sw_rd),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .bus_start(bus_start),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_len_we(bus_len_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .len_ok(len_ok), .byte_done(byte_done), .buf_en(buf_en), .crc_en(crc_en)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_mem[32];
  int m_len, m_hold, m_sidx, m_bidx;
  bit m_ben, m_cen, m_bd;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_sw();
    case (sw_sel)
      2'd1: return m_len;
      2'd2: return m_ben ? ((m_sidx < 32 && m_sidx < m_len) ? m_mem[m_sidx] : 0) : m_hold;
      2'd3: return (m_ben ? 2 : 0) + (m_cen ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  task automatic settle();
    string t;
    #1;
    t = (sw_sel == 2'd3) ? "R2" : (sw_sel == 2'd1) ? "R7" : (sw_sel == 2'd0) ? "R4" : (m_ben ? "R3" : "R9");
    chk(t, sw_rdata, exp_sw());
    chk("R8", bus_rdata, m_ben ? ((m_bidx < 32 && m_bidx < m_len) ? m_mem[m_bidx] : 0) : m_hold);
    chk("R8", bus_done, (m_ben && m_bidx >= m_len) ? 1 : 0);
    chk("R7", len_ok, (m_len >= 1 && m_len <= 32) ? 1 : 0);
    chk("R9", byte_done, m_bd);
    chk("R2", buf_en, m_ben);
    chk("R2", crc_en, m_cen);
  endtask

  task automatic advance();
    bit blk;
    int os;
    @(posedge clk);
    blk = (sw_sel == 2'd2);
    os = m_sidx;
    if (m_ben) begin
      if (bus_start) m_bidx = 0;
      else if ((bus_wr || bus_rd) && m_bidx < 32) begin
        if (bus_wr) m_mem[m_bidx] = bus_wdata;
        m_bidx++;
      end
      if (blk && sw_wr && os < 32) m_mem[os] = sw_wdata;
      if (blk && (sw_wr || sw_rd) && os < 32) m_sidx = os + 1;
    end else begin
      if (bus_start) m_bidx = 0;
      if (blk && sw_wr) m_hold = sw_wdata;
      else if (bus_wr) m_hold = bus_wdata;
      if (bus_wr || bus_rd) m_bd = 1;
      else if (blk && (sw_wr || sw_rd)) m_bd = 0;
    end
    if (sw_rd && sw_sel == 2'd0) m_sidx = 0;
    if (sw_wr && sw_sel == 2'd1) m_len = sw_wdata;
    else if (bus_len_we) m_len = bus_wdata;
    if (sw_wr && sw_sel == 2'd3) begin
      m_ben = sw_wdata[1];
      m_cen = sw_wdata[0];
    end
    @(negedge clk);
    sw_wr = 0; sw_rd = 0; bus_start = 0; bus_wr = 0; bus_rd = 0; bus_len_we = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    sw_sel = s; sw_wdata = d; sw_wr = 1;
    settle(); advance();
  endtask

  task automatic rd(logic [1:0] s, int exp, string tag);
    sw_sel = s; sw_rd = 1;
    settle();
    chk(tag, sw_rdata, exp);
    advance();
  endtask

  task automatic idle();
    settle(); advance();
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    m_len = 0; m_hold = 0; m_sidx = 0; m_bidx = 0; m_ben = 0; m_cen = 0; m_bd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd3, 0, "R1");
    rd(2'd1, 0, "R1");
    wr(2'd3, 8'h02);
    rd(2'd2, 0, "R1");
    wr(2'd3, 8'hFF);
    rd(2'd3, 3, "R2");
    wr(2'd3, 8'h01);
    rd(2'd3, 1, "R2");
    wr(2'd3, 8'h02);
    rd(2'd0, 0, "R4");
    wr(2'd1, 8'd5);
    for (int i = 0; i < 5; i++) wr(2'd2, 8'hA0 + 8'(i));
    rd(2'd0, 0, "R4");
    for (int i = 0; i < 5; i++) rd(2'd2, 32'hA0 + i, "R3");
    rd(2'd2, 0, "R6");
    rd(2'd0, 0, "R4");
    rd(2'd2, 32'hA0, "R4");
    rd(2'd2, 32'hA1, "R3");
    rd(2'd0, 0, "R4");
    rd(2'd2, 32'hA0, "R4");
    wr(2'd1, 8'd32);
    rd(2'd0, 0, "R4");
    for (int i = 0; i < 34; i++) wr(2'd2, 8'h40 + 8'(i));
    rd(2'd2, 0, "R5");
    rd(2'd0, 0, "R4");
    for (int i = 0; i < 32; i++) rd(2'd2, 32'h40 + i, "R5");
    rd(2'd2, 0, "R5");
    wr(2'd1, 8'd0);  settle(); chk("R7", len_ok, 0); advance();
    wr(2'd1, 8'd33); settle(); chk("R7", len_ok, 0); advance();
    wr(2'd1, 8'd1);  settle(); chk("R7", len_ok, 1); advance();
    wr(2'd1, 8'd4);
    bus_start = 1; idle();
    for (int i = 0; i < 4; i++) begin
      bus_rd = 1; settle(); chk("R8", bus_rdata, 32'h40 + i); advance();
    end
    settle(); chk("R8", bus_done, 1); advance();
    bus_start = 1; idle();
    for (int i = 0; i < 3; i++) begin
      bus_wr = 1; bus_wdata = 8'hC0 + 8'(i); idle();
    end
    bus_len_we = 1; bus_wdata = 8'd4; idle();
    rd(2'd0, 0, "R4");
    rd(2'd2, 32'hC0, "R8");
    rd(2'd2, 32'hC1, "R8");
    rd(2'd2, 32'hC2, "R8");
    rd(2'd2, 32'h43, "R8");
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h02);
    rd(2'd0, 0, "R4");
    rd(2'd2, 32'hC0, "R10");
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h5A);
    rd(2'd2, 32'h5A, "R9");
    rd(2'd2, 32'h5A, "R9");
    bus_rd = 1; settle(); chk("R9", bus_rdata, 32'h5A); advance();
    settle(); chk("R9", byte_done, 1); advance();
    rd(2'd2, 32'h5A, "R9");
    settle(); chk("R9", byte_done, 0); advance();
    bus_wr = 1; bus_wdata = 8'h3C; idle();
    rd(2'd2, 32'h3C, "R9");
    wr(2'd3, 8'h02);
    rd(2'd0, 0, "R4");
    rd(2'd2, 32'hC0, "R10");
    rd(2'd2, 32'hC1, "R10");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule